// File: doc/BRIEF.md
# I2C Controller Byte-Transfer Sequencer

This block is the bus-initiating side of a 7-bit I2C port. Software first presents a target address with a direction flag and a transmit byte. It then pulses a 4-bit command word. A single accepted command runs one operation: a start or repeated start, the address byte, one data byte in the chosen direction, and then either a stop or a held bus. The block leaves SCL low while the bus is held and waits for the next command. Line timing comes from a tick generator. Each bit lasts four ticks, and each tick lasts `(prescale+1)*TICK_BASE` clock cycles.

SCL and SDA are modelled as open-drain lines. A `1` on `scl_out` or `sda_out` releases the line, and a `0` pulls it low. The resolved line levels come back on `scl_in` and `sda_in`. When an operation finishes, the block raises one interrupt, whether the operation succeeded, saw a NACK or lost arbitration. That interrupt has a mask and a clear input.

The states and their transitions are as follows:
- `ST_IDLE` goes to `ST_START` on an accepted command.
- `ST_START` goes to `ST_ADDR` after four ticks.
- `ST_ADDR` goes to `ST_DATA` when the target acknowledges the address. On an address NACK it goes to `ST_STOP` or `ST_HOLD`, depending on the STOP bit. On arbitration loss it goes to `ST_IDLE`.
- `ST_DATA` goes to `ST_STOP` or `ST_HOLD` at the end of the byte, and to `ST_IDLE` on arbitration loss.
- `ST_STOP` goes to `ST_IDLE`.
- `ST_HOLD` goes to `ST_START` on a START command, or to `ST_STOP` on a STOP-only command.

Top module: `i2c_ctl_seq`

## Requirements
- R1: After reset, `status` reads 7'h20 and `irq_raw` and `irq_masked` are 0. Both lines are released (`scl_out`=1, `sda_out`=1). The status bits are laid out as follows: bit 0 busy, bit 1 error, bit 2 address-NACK, bit 3 data-NACK, bit 4 arbitration-lost, bit 5 idle, bit 6 bus-busy.
- R2: A command with RUN (bit 0) and START (bit 1) set is accepted in idle. In hold, a command is accepted if RUN is set together with START or STOP (bit 2). Status bit 0 reads 1 no later than four cycles after an accepted command and stays 1 while lines are being sequenced.
- R3: The address/direction input is `{addr[6:0], dir}`, where dir 0 means write. On a write, the address byte and then the data byte are sent MSB first. With STOP set, the operation ends with status 7'h20.
- R4: With dir 1, the received byte appears on `rx_byte`. On the ninth bit of that byte the block drives SDA low if ACK (bit 3) was set, and releases SDA otherwise.
- R5: An address NACK sets bits 2 and 1 and skips the data byte. A stop is still generated when STOP was requested, giving status 7'h26.
- R6: A data NACK on a write sets bits 3 and 1 (7'h2A after a stop).
- R7: Without STOP the block holds the bus, with SCL low and status 7'h40. A later START command produces a repeated start, and a later STOP-only command produces a stop.
- R8: If the block releases SDA high but samples it low while SCL is high during an address bit or a write data bit, it releases both lines, sets bits 4 and 1, clears bit 6 and returns to idle (7'h32).
- R9: `irq_raw` sets at each operation's completion. `irq_masked` is `irq_raw` AND `irq_mask`. Pulsing `irq_clear` clears both.
- R10: A command with RUN clear is ignored. The block stays idle with the lines released and no interrupt.
- R11: Consecutive SCL rising edges within an operation are `4*(prescale+1)*TICK_BASE` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | One-cycle command strobe |
| cmd | input | 4 | Command: RUN, START, STOP, ACK in bits 0..3 |
| addr_dir | input | 8 | Target address in 7:1, direction in bit 0 |
| tx_byte | input | 8 | Byte to transmit |
| prescale | input | PRE_W | SCL period setting |
| irq_mask | input | 1 | Interrupt mask |
| irq_clear | input | 1 | Interrupt clear strobe |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_out | output | 1 | SCL drive, 0 pulls low |
| sda_out | output | 1 | SDA drive, 0 pulls low |
| rx_byte | output | 8 | Last received byte |
| status | output | 7 | Status bits |
| irq_raw | output | 1 | Raw interrupt |
| irq_masked | output | 1 | Masked interrupt |

## Verification
The busy bit is due one cycle after the accepting edge, so the bench polls it on at most four falling edges after the strobe. Completion results (status, received byte, the byte the target model captured, and the masked interrupt) are due on the cycle `irq_raw` rises. A monitor compares them against a queued expectation at the first falling edge where the raw interrupt is high. It then clears the interrupt and confirms the clear one edge later. Line-level results are taken only after completion: the target model's view of the controller's acknowledge, its data-byte count, and the SCL rise spacing, which should be 16 cycles at the bench setting.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_ADDR, ST_DATA, ST_STOP, ST_HOLD
    } seq_state_e;

    localparam int CMD_RUN   = 0;
    localparam int CMD_START = 1;
    localparam int CMD_STOP  = 2;
    localparam int CMD_ACK   = 3;

    localparam int SB_BUSY  = 0;
    localparam int SB_ERR   = 1;
    localparam int SB_ADRN  = 2;
    localparam int SB_DATN  = 3;
    localparam int SB_ARB   = 4;
    localparam int SB_IDLE  = 5;
    localparam int SB_BUSB  = 6;
    localparam int STAT_W   = 7;
endpackage

// File: rtl/i2c_seq_tick.sv
module i2c_seq_tick #(
    parameter int PRE_W = 7,
    parameter int BASE  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    localparam int CNT_W = PRE_W + $clog2(BASE) + 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = CNT_W'((int'(prescale) + 1) * BASE - 1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt == lim)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_seq_irq.sv
module i2c_seq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic clear,
    input  logic mask,
    output logic raw,
    output logic masked
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            raw <= 1'b0;
        else if (done)
            raw <= 1'b1;
        else if (clear)
            raw <= 1'b0;
    end

    assign masked = raw & mask;
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
    import i2c_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_we,
    input  logic [3:0]        cmd,
    input  logic [7:0]        addr_dir,
    input  logic [7:0]        tx_byte,
    input  logic              sda_in,
    output logic              scl_out,
    output logic              sda_out,
    output logic              run,
    output logic              done,
    output logic [7:0]        rx_byte,
    output logic [STAT_W-1:0] status
);
    seq_state_e state, nxt;
    logic [1:0] ph;
    logic [3:0] bitn;
    logic [7:0] addr_lat, tx_lat, rx_sh;
    logic       ack_lat, stop_lat;
    logic       adr_nack, dat_nack, arb_lost, busbsy;
    logic       accept, samp, end_ph, last_bit, rx_mode, drv, arb;

    assign rx_mode  = addr_lat[0];
    assign samp     = tick && ph == 2'd1;
    assign end_ph   = tick && ph == 2'd3;
    assign last_bit = bitn == 4'd8;
    assign accept   = cmd_we && cmd[CMD_RUN] &&
                      ((state == ST_IDLE && cmd[CMD_START]) ||
                       (state == ST_HOLD && (cmd[CMD_START] || cmd[CMD_STOP])));

    always_comb begin
        drv = 1'b1;
        if (state == ST_ADDR)
            drv = last_bit ? 1'b1 : addr_lat[~bitn[2:0]];
        else if (state == ST_DATA)
            drv = rx_mode ? (last_bit ? ~ack_lat : 1'b1)
                          : (last_bit ? 1'b1 : tx_lat[~bitn[2:0]]);
    end

    assign arb = samp && !last_bit && drv && !sda_in &&
                 (state == ST_ADDR || (state == ST_DATA && !rx_mode));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = ST_START;
            ST_HOLD:  if (accept) nxt = cmd[CMD_START] ? ST_START : ST_STOP;
            ST_START: if (end_ph) nxt = ST_ADDR;
            ST_ADDR: begin
                if (arb)
                    nxt = ST_IDLE;
                else if (end_ph && last_bit)
                    nxt = adr_nack ? (stop_lat ? ST_STOP : ST_HOLD) : ST_DATA;
            end
            ST_DATA: begin
                if (arb)
                    nxt = ST_IDLE;
                else if (end_ph && last_bit)
                    nxt = stop_lat ? ST_STOP : ST_HOLD;
            end
            ST_STOP:  if (end_ph) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign done = arb || (state == ST_STOP && end_ph) ||
                  (nxt == ST_HOLD && state != ST_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ph       <= '0;
            bitn     <= '0;
            addr_lat <= '0;
            tx_lat   <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
            ack_lat  <= 1'b0;
            stop_lat <= 1'b0;
            adr_nack <= 1'b0;
            dat_nack <= 1'b0;
            arb_lost <= 1'b0;
            busbsy   <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                ph   <= '0;
                bitn <= '0;
            end else if (tick) begin
                ph <= ph + 1'b1;
                if (ph == 2'd3)
                    bitn <= bitn + 1'b1;
            end
            if (accept) begin
                if (cmd[CMD_START]) begin
                    addr_lat <= addr_dir;
                    tx_lat   <= tx_byte;
                    ack_lat  <= cmd[CMD_ACK];
                end
                stop_lat <= cmd[CMD_STOP];
                adr_nack <= 1'b0;
                dat_nack <= 1'b0;
                arb_lost <= 1'b0;
            end
            if (samp && last_bit && state == ST_ADDR)
                adr_nack <= sda_in;
            if (samp && last_bit && state == ST_DATA && !rx_mode)
                dat_nack <= sda_in;
            if (samp && !last_bit && state == ST_DATA && rx_mode)
                rx_sh <= {rx_sh[6:0], sda_in};
            if (end_ph && last_bit && state == ST_DATA && rx_mode)
                rx_byte <= rx_sh;
            if (arb)
                arb_lost <= 1'b1;
            if (tick && state == ST_START && ph == 2'd2)
                busbsy <= 1'b1;
            else if ((state == ST_STOP && end_ph) || arb)
                busbsy <= 1'b0;
        end
    end

    always_comb begin
        scl_out = 1'b1;
        sda_out = 1'b1;
        unique case (state)
            ST_IDLE: ;
            ST_HOLD: scl_out = 1'b0;
            ST_START: begin
                scl_out = (ph == 2'd0) ? !busbsy : (ph != 2'd3);
                sda_out = (ph < 2'd2);
            end
            ST_ADDR, ST_DATA: begin
                scl_out = (ph == 2'd1) || (ph == 2'd2);
                sda_out = drv;
            end
            ST_STOP: begin
                scl_out = (ph != 2'd0);
                sda_out = (ph >= 2'd2);
            end
            default: ;
        endcase
    end

    assign run = (state == ST_START) || (state == ST_ADDR) ||
                 (state == ST_DATA) || (state == ST_STOP);

    always_comb begin
        status          = '0;
        status[SB_BUSY] = run;
        status[SB_ERR]  = adr_nack | dat_nack | arb_lost;
        status[SB_ADRN] = adr_nack;
        status[SB_DATN] = dat_nack;
        status[SB_ARB]  = arb_lost;
        status[SB_IDLE] = (state == ST_IDLE);
        status[SB_BUSB] = busbsy;
    end
endmodule

// File: rtl/i2c_ctl_seq.sv
module i2c_ctl_seq #(
    parameter int PRE_W     = 7,
    parameter int TICK_BASE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [3:0]       cmd,
    input  logic [7:0]       addr_dir,
    input  logic [7:0]       tx_byte,
    input  logic [PRE_W-1:0] prescale,
    input  logic             irq_mask,
    input  logic             irq_clear,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_out,
    output logic             sda_out,
    output logic [7:0]       rx_byte,
    output logic [6:0]       status,
    output logic             irq_raw,
    output logic             irq_masked
);
    logic tick, run, done, scl_seen;

    assign scl_seen = scl_in;

    i2c_seq_tick #(.PRE_W(PRE_W), .BASE(TICK_BASE)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run && (scl_seen || !scl_out)),
        .prescale(prescale), .tick(tick)
    );

    i2c_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_we(cmd_we), .cmd(cmd),
        .addr_dir(addr_dir), .tx_byte(tx_byte), .sda_in(sda_in),
        .scl_out(scl_out), .sda_out(sda_out), .run(run), .done(done),
        .rx_byte(rx_byte), .status(status)
    );

    i2c_seq_irq u_irq (
        .clk(clk), .rst_n(rst_n), .done(done), .clear(irq_clear),
        .mask(irq_mask), .raw(irq_raw), .masked(irq_masked)
    );
endmodule

// File: rtl/i2c_ctl_seq_chk.sv
module i2c_ctl_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we,
    input logic [3:0] cmd,
    input logic       irq_clear,
    input logic       irq_raw,
    input logic [6:0] status,
    input logic       scl_out,
    input logic       sda_out
);
    // R2
    busy_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd[0] && cmd[1] && status[5]) |=> status[0]);

    // R2
    busy_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> !status[5]);

    // R7
    hold_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && !status[5]) |-> (status[6] && !scl_out));

    // R8
    arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> (scl_out && sda_out && status[5] && status[1] && !status[6]));

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && status[5] && !cmd_we) |=> !irq_raw);

    // R10
    no_run_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !cmd[0] && status[5]) |=> (status[5] && !status[0]));
endmodule

bind i2c_ctl_seq i2c_ctl_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cmd),
    .irq_clear(irq_clear), .irq_raw(irq_raw), .status(status),
    .scl_out(scl_out), .sda_out(sda_out)
);

// File: tb/sim_i2c_ctl_seq.sv
module sim_i2c_ctl_seq;
    localparam int TPR = 1;
    localparam int BASE = 2;
    localparam logic [6:0] TGT_ADDR = 7'h5A;

    typedef struct {
        logic [6:0] st;
        logic [7:0] rx;
        bit         chk_rx;
        logic [7:0] tb;
        bit         chk_tb;
        logic       msk;
        string      req;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_we = 1'b0, irq_mask = 1'b0, irq_clear = 1'b0;
    logic [3:0] cmd_in = '0;
    logic [7:0] addr_in = '0, data_in = '0;
    logic scl_out, sda_out, irq_raw, irq_masked;
    logic [7:0] rx_byte;
    logic [6:0] status;
    logic t_sda = 1'b1, arb_pull = 1'b0, tgt_data_nack = 1'b0;
    logic [7:0] tgt_rd = '0, t_sh = '0, t_last = '0;
    logic prev_scl = 1'b1, prev_sda = 1'b1, t_active = 1'b0, t_addr_ph = 1'b0;
    logic t_match = 1'b0, t_rw = 1'b0, t_mack = 1'b0;
    int t_cnt = 0, t_wcnt = 0, last_rise = -1, scl_gap = 0, cyc = 0;
    int total = 0, bad = 0, pending = 0;
    exp_t q[$];
    wire scl_bus = scl_out;
    wire sda_bus = sda_out & t_sda & !arb_pull;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_ctl_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cmd_in),
        .addr_dir(addr_in), .tx_byte(data_in), .prescale(7'(TPR)),
        .irq_mask(irq_mask), .irq_clear(irq_clear), .scl_in(scl_bus),
        .sda_in(sda_bus), .scl_out(scl_out), .sda_out(sda_out),
        .rx_byte(rx_byte), .status(status), .irq_raw(irq_raw),
        .irq_masked(irq_masked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural target on the bus
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_bus && prev_sda && !sda_bus) begin
                t_active = 1'b1; t_cnt = -1; t_addr_ph = 1'b1; t_sda = 1'b1;
            end else if (scl_bus && !prev_sda && sda_bus) begin
                t_active = 1'b0; t_sda = 1'b1;
            end else if (t_active && !prev_scl && scl_bus) begin
                if (last_rise >= 0) scl_gap = cyc - last_rise;
                last_rise = cyc;
                if (t_cnt < 8) t_sh = {t_sh[6:0], sda_bus};
                else if (t_cnt == 8 && !t_addr_ph && t_rw) t_mack = !sda_bus;
            end else if (t_active && prev_scl && !scl_bus) begin
                t_cnt++;
                if (t_cnt == 8) begin
                    if (t_addr_ph) begin
                        t_match = (t_sh[7:1] == TGT_ADDR); t_rw = t_sh[0]; t_sda = !t_match;
                    end else if (!t_rw) begin
                        t_last = t_sh; t_wcnt++; t_sda = tgt_data_nack;
                    end else t_sda = 1'b1;
                end else if (t_cnt == 9) begin
                    t_cnt = 0;
                    if (t_addr_ph && !t_match) begin
                        t_active = 1'b0; t_sda = 1'b1;
                    end else begin
                        t_addr_ph = 1'b0; t_sda = t_rw ? tgt_rd[7] : 1'b1;
                    end
                end else if (!t_addr_ph && t_rw && t_cnt >= 1 && t_cnt < 8)
                    t_sda = tgt_rd[7 - t_cnt];
            end
            prev_scl = scl_bus; prev_sda = sda_bus;
        end
    end

    // monitor: compares completions against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && irq_raw && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.req, " status"}, 32'(status), 32'(e.st));
                chk("R9 masked irq", 32'(irq_masked), 32'(e.msk));
                if (e.chk_rx) chk("R4 rx_byte", 32'(rx_byte), 32'(e.rx));
                if (e.chk_tb) chk("R3 target byte", 32'(t_last), 32'(e.tb));
                irq_clear = 1'b1;
                @(negedge clk);
                irq_clear = 1'b0;
                chk("R9 raw cleared", 32'(irq_raw), 32'd0);
                chk("R9 masked cleared", 32'(irq_masked), 32'd0);
                pending--;
            end
        end
    end

    task automatic txn(input logic [7:0] a, input logic [7:0] d, input logic [3:0] c,
                       input logic m, input logic [6:0] est, input logic [7:0] erx,
                       input bit crx, input bit ctb, input string req, input bit pull);
        exp_t e;
        int n;
        e.st = est; e.rx = erx; e.chk_rx = crx; e.tb = d; e.chk_tb = ctb;
        e.msk = m; e.req = req;
        q.push_back(e);
        pending++;
        addr_in = a; data_in = d; irq_mask = m; cmd_in = c; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        n = 1;
        while (!status[0] && n < 4) begin @(negedge clk); n++; end
        chk("R2 busy within 4 cycles", 32'(status[0]), 32'd1);
        if (pull) begin
            while (!status[6]) @(negedge clk);
            arb_pull = 1'b1;
        end
        while (pending != 0) @(negedge clk);
        arb_pull = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int wc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", 32'(status), 32'h20);
        chk("R1 irq_raw", 32'(irq_raw), 32'd0);
        chk("R1 irq_masked", 32'(irq_masked), 32'd0);
        chk("R1 scl_out", 32'(scl_out), 32'd1);
        chk("R1 sda_out", 32'(sda_out), 32'd1);

        // R10 command without RUN is ignored
        cmd_in = 4'b0010; addr_in = 8'hB4; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 status", 32'(status), 32'h20);
        chk("R10 scl_out", 32'(scl_out), 32'd1);
        chk("R10 irq_raw", 32'(irq_raw), 32'd0);

        // R3 write with stop, R11 SCL spacing
        txn(8'hB4, 8'hC3, 4'b0111, 1'b1, 7'h20, 8'h00, 0, 1, "R3", 0);
        chk("R11 scl rise spacing", 32'(scl_gap), 32'(4 * (TPR + 1) * BASE));
        chk("R3 bus released scl", 32'(scl_out), 32'd1);

        // R6 data NACK
        tgt_data_nack = 1'b1;
        txn(8'hB4, 8'h3C, 4'b0111, 1'b0, 7'h2A, 8'h00, 0, 1, "R6", 0);
        tgt_data_nack = 1'b0;

        // R5 address NACK, data phase skipped
        wc = t_wcnt;
        txn(8'h22, 8'h99, 4'b0111, 1'b1, 7'h26, 8'h00, 0, 0, "R5", 0);
        chk("R5 no data byte", 32'(t_wcnt), 32'(wc));

        // R7 hold, then repeated start read with NACK (R4)
        txn(8'hB4, 8'h81, 4'b0011, 1'b1, 7'h40, 8'h00, 0, 1, "R7", 0);
        chk("R7 scl held low", 32'(scl_out), 32'd0);
        tgt_rd = 8'hA5;
        txn(8'hB5, 8'h00, 4'b0111, 1'b1, 7'h20, 8'hA5, 1, 0, "R4", 0);
        chk("R4 nack on last byte", 32'(t_mack), 32'd0);

        // R4 read with ACK enabled
        tgt_rd = 8'hDE;
        txn(8'hB5, 8'h00, 4'b1111, 1'b0, 7'h20, 8'hDE, 1, 0, "R4", 0);
        chk("R4 ack driven", 32'(t_mack), 32'd1);

        // R7 hold then STOP-only command
        txn(8'hB4, 8'h42, 4'b0011, 1'b1, 7'h40, 8'h00, 0, 1, "R7", 0);
        txn(8'hB4, 8'h42, 4'b0101, 1'b1, 7'h20, 8'h00, 0, 0, "R7", 0);

        // R8 arbitration loss
        txn(8'hB4, 8'h11, 4'b0111, 1'b1, 7'h32, 8'h00, 0, 0, "R8", 1);
        chk("R8 scl released", 32'(scl_out), 32'd1);
        chk("R8 sda released", 32'(sda_out), 32'd1);

        // recovery after arbitration loss
        txn(8'hB4, 8'h6E, 4'b0111, 1'b1, 7'h20, 8'h00, 0, 1, "R3", 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule